// File: doc/BRIEF.md
# Masked interrupt status aggregator

This block gathers the eight interrupt sources of a two-channel serial controller into one 8-bit status register. It masks that register with an 8-bit enable register and produces a single active-low interrupt request for the CPU. Four of the sources are sticky events. Each of these holds until its own clearing action arrives: the input-port change flag clears on a read of the port-change register, each channel's break-change flag clears on that channel's reset command, and the counter-ready flag clears on a stop-counter command. The other four sources are live level flags from the receive and transmit level logic of each channel. The register samples them on every clock.

Software reads the status value at any time, and the mask never hides it. Software writes the mask through a write strobe. The surrounding logic drives the set strobes, the clear strobes and the level flags. The input-port change detector is built in. It compares the I/O pins of both channels against their values on the previous clock, and a 4-bit enable field selects which pin positions count. The request output is registered, so it cannot glitch.

Top module: `irq_status_agg`

## Requirements
- R1: The status bits, from bit 7 down to bit 0, are: input-port change, break change B, receive B, transmit B, counter ready, break change A, receive A, transmit A. The mask register uses the same layout, with 1 meaning enabled.
- R2: After reset, the status reads 0x00, the mask reads 0x00 and irq_n is high.
- R3: A clock edge with mask_wr_en high loads mask_wr_data into the mask, and mask_rd shows it after that edge.
- R4: irq_n is low exactly when, at the previous clock edge, the status ANDed with the mask was non-zero. This gives one clock of latency behind the status register.
- R5: status_rd always returns the true status, whatever the mask value.
- R6: Status bit 7 sets when a pin position i with port_chg_en[i]=1 differs on either channel from its value at the previous edge. Changes on positions whose enable bit is 0 have no effect. No change is seen on the first edge after reset.
- R7: Status bit 7 stays set until a clock edge with port_chg_rd high clears it.
- R8: brk_a_evt sets bit 2 and brk_b_evt sets bit 6. Each bit clears only on its own channel's reset command (brk_a_clr or brk_b_clr). The other channel's command leaves it unchanged.
- R9: ctr_ready_evt sets bit 3, and only ctr_stop clears it.
- R10: Bits 0, 1, 4 and 5 equal tx_a_lvl, rx_a_lvl, tx_b_lvl and rx_b_lvl as sampled at the previous clock edge.
- R11: When a set and a clear for the same sticky bit fall on the same edge, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_a | input | NUM_IO | Channel A general-purpose input pins |
| io_b | input | NUM_IO | Channel B general-purpose input pins |
| port_chg_en | input | NUM_IO | Per-position enable for change detection |
| port_chg_rd | input | 1 | Port-change register read strobe (clears bit 7) |
| brk_a_evt | input | 1 | Channel A break start/end pulse |
| brk_b_evt | input | 1 | Channel B break start/end pulse |
| brk_a_clr | input | 1 | Channel A reset-break-change command |
| brk_b_clr | input | 1 | Channel B reset-break-change command |
| ctr_ready_evt | input | 1 | Counter/timer ready pulse |
| ctr_stop | input | 1 | Stop-counter command |
| rx_a_lvl | input | 1 | Channel A receive level condition |
| tx_a_lvl | input | 1 | Channel A transmit level condition |
| rx_b_lvl | input | 1 | Channel B receive level condition |
| tx_b_lvl | input | 1 | Channel B transmit level condition |
| mask_wr_en | input | 1 | Mask write strobe |
| mask_wr_data | input | 8 | Mask write value |
| status_rd | output | 8 | Unmasked status register |
| mask_rd | output | 8 | Mask register |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
A wrong status bit shows on status_rd one edge after the stimulus that should have produced it. When the mask enables that bit, the error reaches irq_n one edge later still. A sticky bit that clears too early, or never clears, diverges from the bench's model on the first cycle after the set or clear strobe. A crossed channel clear or a wrong set-versus-clear priority is exposed by directed cycles that apply both strobes on the same edge. A mask value or mask gating error is found by the sweep over all 256 masks against every level and sticky pattern, because irq_n then disagrees with the arithmetic expectation.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
   localparam int unsigned ST_W    = 8;
   localparam int unsigned CH_SPAN = 4;
   localparam int unsigned B_TX_A  = 0;
   localparam int unsigned B_RX_A  = 1;
   localparam int unsigned B_BRK_A = 2;
   localparam int unsigned B_CTR   = 3;
   localparam int unsigned B_TX_B  = 4;
   localparam int unsigned B_RX_B  = 5;
   localparam int unsigned B_BRK_B = 6;
   localparam int unsigned B_PORT  = 7;
   typedef logic [ST_W-1:0] st_vec_t;
endpackage

// File: rtl/irq_sticky_flag.sv
module irq_sticky_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);
   // set has priority so no event is dropped
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flag_o <= 1'b0;
      else if (set_i)  flag_o <= 1'b1;
      else if (clr_i)  flag_o <= 1'b0;
   end
endmodule

// File: rtl/irq_port_change.sv
module irq_port_change #(
   parameter int unsigned NUM_IO = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_IO-1:0] io_a_i,
   input  logic [NUM_IO-1:0] io_b_i,
   input  logic [NUM_IO-1:0] en_i,
   output logic              change_o
);
   logic [NUM_IO-1:0] prev_a, prev_b, diff;
   logic              primed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_a <= '0;
         prev_b <= '0;
         primed <= 1'b0;
      end else begin
         prev_a <= io_a_i;
         prev_b <= io_b_i;
         primed <= 1'b1;
      end
   end

   assign diff     = ((io_a_i ^ prev_a) | (io_b_i ^ prev_b)) & en_i;
   assign change_o = primed & (|diff);
endmodule

// File: rtl/irq_req_out.sv
module irq_req_out #(
   parameter bit REGISTERED = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  irq_agg_pkg::st_vec_t  status_i,
   input  irq_agg_pkg::st_vec_t  mask_i,
   output logic                  irq_n_o
);
   logic any_active;
   assign any_active = |(status_i & mask_i);

   generate
      if (REGISTERED) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_n_o <= 1'b1;
            else        irq_n_o <= ~any_active;
         end
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign irq_n_o = ~any_active;
      end
   endgenerate
endmodule

// File: rtl/irq_status_agg.sv
module irq_status_agg #(
   parameter int unsigned NUM_IO         = 4,
   parameter bit          IRQ_REGISTERED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_IO-1:0] io_a,
   input  logic [NUM_IO-1:0] io_b,
   input  logic [NUM_IO-1:0] port_chg_en,
   input  logic              port_chg_rd,
   input  logic              brk_a_evt,
   input  logic              brk_b_evt,
   input  logic              brk_a_clr,
   input  logic              brk_b_clr,
   input  logic              ctr_ready_evt,
   input  logic              ctr_stop,
   input  logic              rx_a_lvl,
   input  logic              tx_a_lvl,
   input  logic              rx_b_lvl,
   input  logic              tx_b_lvl,
   input  logic              mask_wr_en,
   input  logic [7:0]        mask_wr_data,
   output logic [7:0]        status_rd,
   output logic [7:0]        mask_rd,
   output logic              irq_n
);
   import irq_agg_pkg::*;
   localparam int unsigned NCH = 2;

   generate
      if (NUM_IO < 1 || NUM_IO > 8) begin : g_bad_io
         $error("irq_status_agg: NUM_IO must lie in 1..8");
      end
   endgenerate

   st_vec_t status, mask_q;
   logic [NCH-1:0] brk_set, brk_clr, brk_flag, rx_lvl, tx_lvl;
   logic [NCH-1:0] rx_q, tx_q;
   logic           port_change, port_flag, ctr_flag;

   assign brk_set = {brk_b_evt, brk_a_evt};
   assign brk_clr = {brk_b_clr, brk_a_clr};
   assign rx_lvl  = {rx_b_lvl, rx_a_lvl};
   assign tx_lvl  = {tx_b_lvl, tx_a_lvl};

   irq_port_change #(.NUM_IO(NUM_IO)) u_pchg (
      .clk(clk), .rst_n(rst_n), .io_a_i(io_a), .io_b_i(io_b),
      .en_i(port_chg_en), .change_o(port_change)
   );

   irq_sticky_flag u_port_flag (
      .clk(clk), .rst_n(rst_n), .set_i(port_change), .clr_i(port_chg_rd), .flag_o(port_flag)
   );

   irq_sticky_flag u_ctr_flag (
      .clk(clk), .rst_n(rst_n), .set_i(ctr_ready_evt), .clr_i(ctr_stop), .flag_o(ctr_flag)
   );

   genvar ch;
   generate
      for (ch = 0; ch < NCH; ch++) begin : g_chan
         irq_sticky_flag u_brk (
            .clk(clk), .rst_n(rst_n), .set_i(brk_set[ch]), .clr_i(brk_clr[ch]),
            .flag_o(brk_flag[ch])
         );
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rx_q[ch] <= 1'b0;
               tx_q[ch] <= 1'b0;
            end else begin
               rx_q[ch] <= rx_lvl[ch];
               tx_q[ch] <= tx_lvl[ch];
            end
         end
         assign status[B_TX_A  + ch*CH_SPAN] = tx_q[ch];
         assign status[B_RX_A  + ch*CH_SPAN] = rx_q[ch];
         assign status[B_BRK_A + ch*CH_SPAN] = brk_flag[ch];
      end
   endgenerate

   assign status[B_CTR]  = ctr_flag;
   assign status[B_PORT] = port_flag;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          mask_q <= '0;
      else if (mask_wr_en) mask_q <= mask_wr_data;
   end

   irq_req_out #(.REGISTERED(IRQ_REGISTERED)) u_req (
      .clk(clk), .rst_n(rst_n), .status_i(status), .mask_i(mask_q), .irq_n_o(irq_n)
   );

   assign status_rd = status;
   assign mask_rd   = mask_q;
endmodule

// File: rtl/irq_status_agg_chk.sv
module irq_status_agg_chk #(
   parameter int unsigned NUM_IO         = 4,
   parameter bit          IRQ_REGISTERED = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NUM_IO-1:0] io_a,
   input logic [NUM_IO-1:0] io_b,
   input logic [NUM_IO-1:0] port_chg_en,
   input logic              port_chg_rd,
   input logic              brk_a_evt,
   input logic              brk_b_evt,
   input logic              brk_a_clr,
   input logic              brk_b_clr,
   input logic              ctr_ready_evt,
   input logic              ctr_stop,
   input logic              rx_a_lvl,
   input logic              tx_a_lvl,
   input logic              rx_b_lvl,
   input logic              tx_b_lvl,
   input logic              mask_wr_en,
   input logic [7:0]        mask_wr_data,
   input logic [7:0]        status_rd,
   input logic [7:0]        mask_rd,
   input logic              irq_n
);
   // R3
   mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mask_wr_en |=> mask_rd == $past(mask_wr_data));
   // R4
   irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      IRQ_REGISTERED |=> irq_n == !(|($past(status_rd & mask_rd))));
   // R8
   brk_a_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      brk_a_evt |=> status_rd[2]);
   // R8
   brk_a_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status_rd[2] && !brk_a_clr) |=> status_rd[2]);
   // R8
   brk_b_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status_rd[6] && !brk_b_clr) |=> status_rd[6]);
   // R9
   ctr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctr_stop && !ctr_ready_evt) |=> !status_rd[3]);
   // R7
   port_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status_rd[7] && !port_chg_rd) |=> status_rd[7]);
   // R10
   level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (status_rd[0] == $past(tx_a_lvl)) && (status_rd[5] == $past(rx_b_lvl)));
   // R11
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctr_ready_evt && ctr_stop) |=> status_rd[3]);
endmodule

bind irq_status_agg irq_status_agg_chk #(.NUM_IO(NUM_IO), .IRQ_REGISTERED(IRQ_REGISTERED)) u_chk (.*);

// File: tb/tb_irq_status_agg.sv
module tb_irq_status_agg;
   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic       rst_n;
   logic [3:0] io_a, io_b, port_chg_en;
   logic       port_chg_rd, brk_a_evt, brk_b_evt, brk_a_clr, brk_b_clr;
   logic       ctr_ready_evt, ctr_stop, rx_a_lvl, tx_a_lvl, rx_b_lvl, tx_b_lvl;
   logic       mask_wr_en;
   logic [7:0] mask_wr_data, status_rd, mask_rd;
   logic       irq_n;

   irq_status_agg dut (.*);

   int   n_chk = 0, n_bad = 0;
   bit   finished = 0;
   string req = "R2";

   logic [7:0] m_st, m_mk;
   logic       m_irq, m_primed;
   logic [3:0] m_pa, m_pb;

   task automatic chk(string what, logic [7:0] act, logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
      end
   endtask

   task automatic compare();
      chk("status_rd", status_rd, m_st);
      chk("mask_rd", mask_rd, m_mk);
      chk("irq_n", {7'd0, irq_n}, {7'd0, m_irq});
   endtask

   task automatic clear_pulses();
      port_chg_rd = 0; brk_a_evt = 0; brk_b_evt = 0; brk_a_clr = 0; brk_b_clr = 0;
      ctr_ready_evt = 0; ctr_stop = 0; mask_wr_en = 0;
   endtask

   task automatic step();
      logic [7:0] nx;
      logic       chg;
      @(posedge clk);
      m_irq = ~|(m_st & m_mk);
      chg = m_primed && (|(((io_a ^ m_pa) | (io_b ^ m_pb)) & port_chg_en));
      nx    = m_st;
      nx[0] = tx_a_lvl; nx[1] = rx_a_lvl; nx[4] = tx_b_lvl; nx[5] = rx_b_lvl;
      nx[2] = brk_a_evt | (m_st[2] & ~brk_a_clr);
      nx[6] = brk_b_evt | (m_st[6] & ~brk_b_clr);
      nx[3] = ctr_ready_evt | (m_st[3] & ~ctr_stop);
      nx[7] = chg | (m_st[7] & ~port_chg_rd);
      if (mask_wr_en) m_mk = mask_wr_data;
      m_st = nx; m_primed = 1'b1; m_pa = io_a; m_pb = io_b;
      @(negedge clk);
      compare();
      clear_pulses();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      rst_n = 0; io_a = 0; io_b = 0; port_chg_en = 0;
      rx_a_lvl = 0; tx_a_lvl = 0; rx_b_lvl = 0; tx_b_lvl = 0; mask_wr_data = 0;
      clear_pulses();
      m_st = 0; m_mk = 0; m_irq = 1; m_primed = 0; m_pa = 0; m_pb = 0;
      repeat (3) @(negedge clk);
      req = "R2";
      compare();
      rst_n = 1;
      step();

      // Sweep: sticky pattern x level pattern x every mask (R1 R3 R4 R5 R10)
      port_chg_en = 4'b0001;
      for (int s = 0; s < 16; s++) begin
         req = "R1";
         brk_a_evt = s[0]; ctr_ready_evt = s[1]; brk_b_evt = s[2];
         if (s[3]) io_a[0] = ~io_a[0];
         step();
         for (int l = 0; l < 16; l++) begin
            {rx_b_lvl, tx_b_lvl, rx_a_lvl, tx_a_lvl} = 4'(l);
            for (int m = 0; m < 256; m++) begin
               req = (m[0]) ? "R4" : "R5";
               mask_wr_en = 1; mask_wr_data = 8'(m);
               step();
            end
         end
         req = "R3";
         brk_a_clr = 1; brk_b_clr = 1; ctr_stop = 1; port_chg_rd = 1;
         mask_wr_en = 1; mask_wr_data = 8'h00;
         {rx_b_lvl, tx_b_lvl, rx_a_lvl, tx_a_lvl} = 4'd0;
         step();
      end

      // R6: disabled position ignored, enabled channel B position counts
      req = "R6";
      mask_wr_en = 1; mask_wr_data = 8'hFF; step();
      port_chg_en = 4'b0100;
      io_a[1] = ~io_a[1]; io_b[3] = ~io_b[3]; step(); step();
      io_b[2] = ~io_b[2]; step(); step();
      // R7: read clears; R11: read together with a change keeps it set
      req = "R7";
      port_chg_rd = 1; step(); step();
      req = "R11";
      io_a[2] = ~io_a[2]; port_chg_rd = 1; step(); step();
      req = "R7";
      port_chg_rd = 1; step();

      // R8: per-channel break clear isolation
      req = "R8";
      brk_a_evt = 1; step();
      brk_b_clr = 1; step();
      brk_b_evt = 1; brk_a_clr = 1; step();
      brk_a_clr = 1; step();
      brk_b_clr = 1; step();
      req = "R11";
      brk_a_evt = 1; brk_a_clr = 1; step();
      brk_b_evt = 1; brk_b_clr = 1; step();

      // R9: counter ready set and stop
      req = "R9";
      ctr_ready_evt = 1; step(); step();
      ctr_stop = 1; step();
      req = "R11";
      ctr_ready_evt = 1; ctr_stop = 1; step();

      // R10 level toggling with mask off
      req = "R10";
      mask_wr_en = 1; mask_wr_data = 8'h00; step();
      tx_a_lvl = 1; rx_b_lvl = 1; step();
      tx_a_lvl = 0; rx_a_lvl = 1; tx_b_lvl = 1; step(); step();

      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule